// File: doc/BRIEF.md
# Mode-Controlled Integer Arithmetic/Logic Unit

This block is the integer arithmetic and logic stage of a simple processor datapath. Each cycle it takes two operands and a four-bit operation code, and it produces a result word, a carry flag and a signed-overflow flag. It covers addition and subtraction in signed and unsigned forms, the four bitwise operations AND, OR, XOR and NOR, and signed and unsigned less-than comparison. Operand selection, immediate extension and instruction decode all happen upstream.

A single ripple adder does all the arithmetic. Subtraction and comparison feed it the inverted second operand with a carry-in of one. The overflow flag is the carry into the top bit XORed with the carry out of it, and only the signed modes pass it to the output. The function is purely combinational. A single output register stage closes the timing path, so every result appears one clock after its operands and code are applied.

Top module: `alu_unit`

## Requirements
- R1: Code 0x0 (signed add) and code 0x1 (unsigned add) produce opA+opB modulo 2^WIDTH. carryOut is the carry out of the top bit.
- R2: Code 0x2 (signed subtract) and code 0x3 (unsigned subtract) produce opA+~opB+1 modulo 2^WIDTH. carryOut is the adder carry out, which is 1 exactly when no borrow occurs (opA >= opB unsigned).
- R3: The unsigned arithmetic codes 0x1 and 0x3 never raise overflow.
- R4: For codes 0x0 and 0x2, overflow is 1 exactly when the two adder inputs (opA and opB, or opA and ~opB) share a sign and the result has the other sign. An add of operands with opposite signs never overflows.
- R5: Codes 0x4, 0x5, 0x6 and 0x7 produce opA AND opB, opA OR opB, opA XOR opB and NOT(opA OR opB), bit by bit.
- R6: Code 0xA gives 1 when opA < opB as two's complement, else 0. Code 0xB gives 1 when opA < opB as unsigned, else 0. Both results are zero-extended, so bits WIDTH-1..1 are 0.
- R7: The logic codes (0x4 to 0x7) and the comparison codes (0xA, 0xB) drive carryOut and overflow to 0.
- R8: The unused codes 0x8, 0x9 and 0xC to 0xF give a zero result with carryOut and overflow both 0.
- R9: The outputs are registered. A code and operands present at a rising clock edge appear on the outputs after that edge. While rstN is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opCode | input | 4 | Operation code |
| result | output | WIDTH | Registered result word |
| carryOut | output | 1 | Registered adder carry out (arithmetic codes only) |
| overflow | output | 1 | Registered signed overflow (codes 0x0 and 0x2 only) |

## Verification
The properties look at the code and the operands as sampled one edge earlier. They assume those inputs are known values at every rising edge after reset, and they make no assumption about how codes follow one another. The bench changes its inputs only on falling edges, well away from the sampling edge, and it keeps them at defined values through reset. The random phase draws its codes from all sixteen values, so the unused codes also reach the properties.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    OP_ADD  = 4'h0,
    OP_ADDU = 4'h1,
    OP_SUB  = 4'h2,
    OP_SUBU = 4'h3,
    OP_AND  = 4'h4,
    OP_OR   = 4'h5,
    OP_XOR  = 4'h6,
    OP_NOR  = 4'h7,
    OP_SLT  = 4'hA,
    OP_SLTU = 4'hB
  } alu_op_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic invertB;     // feed ~opB into the adder
    logic carryIn;     // adder carry-in
    logic selSum;      // result from adder
    logic selAnd;
    logic selOr;
    logic selXor;
    logic selNor;
    logic selLess;     // result is the comparison bit
    logic lessUnsigned;
    logic keepCarry;   // expose carry flag
    logic keepOvf;     // expose overflow flag
  } alu_ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [CODE_W-1:0] opCode,
  output alu_ctrl_t         ctrl
);

  always_comb begin
    ctrl = '0;
    case (opCode)
      OP_ADD:  begin ctrl.selSum = 1'b1; ctrl.keepCarry = 1'b1; ctrl.keepOvf = 1'b1; end
      OP_ADDU: begin ctrl.selSum = 1'b1; ctrl.keepCarry = 1'b1; end
      OP_SUB:  begin
        ctrl.selSum = 1'b1; ctrl.invertB = 1'b1; ctrl.carryIn = 1'b1;
        ctrl.keepCarry = 1'b1; ctrl.keepOvf = 1'b1;
      end
      OP_SUBU: begin
        ctrl.selSum = 1'b1; ctrl.invertB = 1'b1; ctrl.carryIn = 1'b1;
        ctrl.keepCarry = 1'b1;
      end
      OP_AND:  ctrl.selAnd = 1'b1;
      OP_OR:   ctrl.selOr  = 1'b1;
      OP_XOR:  ctrl.selXor = 1'b1;
      OP_NOR:  ctrl.selNor = 1'b1;
      OP_SLT:  begin ctrl.selLess = 1'b1; ctrl.invertB = 1'b1; ctrl.carryIn = 1'b1; end
      OP_SLTU: begin
        ctrl.selLess = 1'b1; ctrl.invertB = 1'b1; ctrl.carryIn = 1'b1;
        ctrl.lessUnsigned = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] res,
  output logic             carryFlag,
  output logic             ovfFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addendB;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   carryChain;
  logic             ovfRaw;
  logic             lessBit;

  assign addendB       = ctrl.invertB ? ~opB : opB;
  assign carryChain[0] = ctrl.carryIn;

  // Bit-sliced ripple adder: one full adder per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign sumBits[i]      = opA[i] ^ addendB[i] ^ carryChain[i];
    assign carryChain[i+1] = (opA[i] & addendB[i]) |
                             (carryChain[i] & (opA[i] ^ addendB[i]));
  end

  // Carry into sign bit versus carry out of it
  assign ovfRaw  = carryChain[MSB] ^ carryChain[WIDTH];
  assign lessBit = ctrl.lessUnsigned ? ~carryChain[WIDTH] : (sumBits[MSB] ^ ovfRaw);

  always_comb begin
    res = '0;
    if (ctrl.selSum)  res = sumBits;
    if (ctrl.selAnd)  res = opA & opB;
    if (ctrl.selOr)   res = opA | opB;
    if (ctrl.selXor)  res = opA ^ opB;
    if (ctrl.selNor)  res = ~(opA | opB);
    if (ctrl.selLess) res = {{MSB{1'b0}}, lessBit};
  end

  assign carryFlag = ctrl.keepCarry & carryChain[WIDTH];
  assign ovfFlag   = ctrl.keepOvf & ovfRaw;

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [CODE_W-1:0] opCode,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut,
  output logic              overflow
);

  localparam int MSB = WIDTH - 1;

  alu_ctrl_t        ctrl;
  logic [WIDTH-1:0] resNext;
  logic             carryNext;
  logic             ovfNext;

  alu_decode u_decode (
    .opCode (opCode),
    .ctrl   (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .ctrl      (ctrl),
    .opA       (opA),
    .opB       (opB),
    .res       (resNext),
    .carryFlag (carryNext),
    .ovfFlag   (ovfNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      carryOut <= 1'b0;
      overflow <= 1'b0;
    end else begin
      result   <= resNext;
      carryOut <= carryNext;
      overflow <= ovfNext;
    end
  end

  // R3: unsigned arithmetic never flags overflow
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_ADDU || opCode == OP_SUBU) |=> !overflow);

  // R4: an add of opposite-sign operands cannot overflow
  p_mixed_sign_add_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_ADD && opA[MSB] != opB[MSB]) |=> !overflow);

  // R4: a flagged signed add shows a sign flip from the common operand sign
  p_ovf_sign_flip_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_ADD && opA[MSB] == opB[MSB]) |=>
      (overflow == (result[MSB] != $past(opA[MSB]))));

  // R6: comparison result is zero-extended
  p_less_zero_ext_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_SLT || opCode == OP_SLTU) |=> (result[MSB:1] == '0));

  // R7: logic and comparison codes clear both flags
  p_flags_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((opCode >= 4'h4 && opCode <= 4'h7) || opCode == OP_SLT || opCode == OP_SLTU)
      |=> (!carryOut && !overflow));

  // R8: unused codes give all-zero outputs
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == 4'h8 || opCode == 4'h9 || opCode >= 4'hC)
      |=> (result == '0 && !carryOut && !overflow));

  // R9: outputs are cleared the edge after reset is applied
  p_reset_clear_r9: assert property (@(posedge clk)
    !rstN |=> (result == '0 && !carryOut && !overflow));

endmodule

// File: tb/tb_alu_unit.sv
module tb_alu_unit;

  localparam int W = 32;

  typedef struct packed {
    logic [3:0]   code;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] expRes;
    logic         expC;
    logic         expV;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R1 R4 signed add overflow
    '{4'h1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0}, // R1 R3
    '{4'h0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R1 carry, no overflow
    '{4'h2, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b1}, // R2 R4 sub overflow
    '{4'h3, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0}, // R2 R3 borrow
    '{4'h2, 32'h00000005, 32'h00000005, 32'h00000000, 1'b1, 1'b0}, // R2 equal
    '{4'h4, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0}, // R5 R7
    '{4'h5, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0, 1'b0}, // R5
    '{4'h6, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0, 1'b0}, // R5
    '{4'h7, 32'h00000000, 32'h00000000, 32'hFFFFFFFF, 1'b0, 1'b0}, // R5
    '{4'hA, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R6 signed less
    '{4'hB, 32'h80000000, 32'h00000001, 32'h00000000, 1'b0, 1'b0}, // R6 unsigned not less
    '{4'hA, 32'h7FFFFFFF, 32'h80000000, 32'h00000000, 1'b0, 1'b0}, // R6 across overflow
    '{4'hB, 32'h00000001, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0}, // R6 R7
    '{4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0}, // R8
    '{4'h0, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0, 1'b0}  // R4 mixed signs
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic [3:0]   opCode = '0;
  logic [W-1:0] result;
  logic         carryOut;
  logic         overflow;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_unit #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opCode(opCode),
    .result(result), .carryOut(carryOut), .overflow(overflow)
  );

  // Independent reference built from the requirement text
  function automatic void refModel(input logic [3:0] c, input logic [W-1:0] a,
                                   input logic [W-1:0] b, output logic [W-1:0] r,
                                   output logic co, output logic ov);
    logic [W:0]   wide;
    logic [W-1:0] bb;
    r = '0; co = 1'b0; ov = 1'b0;
    case (c)
      4'h0, 4'h1, 4'h2, 4'h3: begin
        bb   = (c[1]) ? ~b : b;
        wide = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, c[1]};
        r    = wide[W-1:0];
        co   = wide[W];
        if (!c[0]) ov = (a[W-1] == bb[W-1]) && (r[W-1] != a[W-1]);
      end
      4'h4: r = a & b;
      4'h5: r = a | b;
      4'h6: r = a ^ b;
      4'h7: r = ~(a | b);
      4'hA: r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      4'hB: r = {{(W-1){1'b0}}, (a < b)};
      default: r = '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] expR,
                       input logic expC, input logic expV);
    testsRun++;
    if (result !== expR || carryOut !== expC || overflow !== expV) begin
      testsFailed++;
      $display("FAIL %s: code=%h a=%h b=%h got res=%h c=%b v=%b exp res=%h c=%b v=%b",
               tag, opCode, opA, opB, result, carryOut, overflow, expR, expC, expV);
    end
  endtask

  // Apply on a falling edge, capture on the rising edge, read on the next falling edge
  task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    opCode = c; opA = a; opB = b;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] r;
    logic co, ov;
    logic [W-1:0] corners [5];
    corners[0] = 32'h0; corners[1] = 32'h1; corners[2] = 32'h7FFFFFFF;
    corners[3] = 32'h80000000; corners[4] = 32'hFFFFFFFF;

    // R9: reset holds outputs at zero even with live inputs
    @(negedge clk);
    opCode = 4'h7; opA = '0; opB = '0;
    @(posedge clk); @(negedge clk);
    check("R9 reset", '0, 1'b0, 1'b0);
    rstN = 1'b1;

    // R9: first result appears one edge later
    apply(4'h7, '0, '0);
    check("R9 latency", 32'hFFFFFFFF, 1'b0, 1'b0);

    // Directed vector table
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i].code, VECS[i].a, VECS[i].b);
      check("R1-table", VECS[i].expRes, VECS[i].expC, VECS[i].expV);
    end

    // R8: every unused code clears outputs
    for (int c = 8; c < 16; c++) begin
      if (c == 10 || c == 11) continue;
      apply(4'(c), 32'hDEADBEEF, 32'h12345678);
      check("R8 unused", '0, 1'b0, 1'b0);
    end

    // R1 R2 R3 R4 R5 R6 R7: all codes over all corner operand pairs
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 5; i++) begin
        for (int j = 0; j < 5; j++) begin
          apply(4'(c), corners[i], corners[j]);
          refModel(4'(c), corners[i], corners[j], r, co, ov);
          check("R4 corner", r, co, ov);
        end
      end
    end

    // Random operands and codes
    for (int k = 0; k < 2000; k++) begin
      logic [3:0]   rc;
      logic [W-1:0] ra, rb;
      rc = 4'($urandom_range(0, 15));
      ra = $urandom;
      rb = $urandom;
      apply(rc, ra, rb);
      refModel(rc, ra, rb, r, co, ov);
      check("R6 random", r, co, ov);
    end

    // R9: reset in mid-run clears the register
    apply(4'h0, 32'hFFFFFFFF, 32'h1);
    check("R1 pre-reset", 32'h0, 1'b1, 1'b0);
    rstN = 1'b0;
    apply(4'h5, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R9 reset again", '0, 1'b0, 1'b0);
    rstN = 1'b1;

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule